// File: doc/BRIEF.md
# Seeded CRC / Pseudo-Random Sequence Shift Register

This block is a parameterised linear feedback shift register (8 bits by default) in Galois form. Its feedback taps come from a writable polynomial register. A second register holds a seed. While the block is enabled it advances once per clock. A serial data bit is folded into the feedback, so a stream on that input builds a CRC in the state. When the data input is held low, the register instead steps through a pseudo-random sequence, and its top bit forms a bit stream at the clock rate.

The block compares the state with the seed on every cycle. The compare type is chosen at run time as equal, unsigned less-or-equal, or unsigned less-than. In equal mode the compare flags the sequence epoch, which is the cycle in which the sequence passes back through the seed. The compare result drives the auxiliary output and a registered interrupt. Writing the seed while the block is disabled also copies it into the state, which is how a run is started from a known value. A pass mode overrides the register path: the data input goes to the primary output, the clock goes to the auxiliary output, and each rising edge of the data input raises an interrupt.

Top module: `crc_prs_core`

## Requirements
- R1: While reset is held, the state holds the seed default (all ones), so primary_out is 1, aux_out is 0 and irq_out is 0.
- R2: A seed write with enable low loads the written value into both the seed and the state at the next edge. With enable high, a seed write changes only the seed.
- R3: A polynomial write takes effect at the next edge, whatever the enable state, and its value sets the taps for every later step.
- R4: With enable high and pass mode low, at each edge fb = state[MSB] XOR ser_in, and the next state is (state << 1) XOR (fb ? poly : 0).
- R5: With enable low, or with pass mode high, the state does not change except through a seed write made while disabled.
- R6: Outside pass mode, primary_out equals the MSB of the state.
- R7: When cmp_mode[0] = 0, the compare is true when state == seed. During a free-running sequence this marks one cycle per period.
- R8: When cmp_mode[0] = 1, the compare is an unsigned state <= seed if cmp_mode[1] = 0, and state < seed if cmp_mode[1] = 1.
- R9: Outside pass mode, aux_out shows the compare while enable is high and stays 0 while enable is low.
- R10: Outside pass mode, irq_out is high in the cycle after a cycle in which enable was high and the compare was true, and low otherwise.
- R11: In pass mode, primary_out follows ser_in and aux_out follows clk.
- R12: In pass mode, irq_out is high for one cycle, one edge after the edge at which ser_in is first sampled high following a low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advances the register each clock |
| pass_mode | input | 1 | Routes the inputs straight to the outputs |
| cmp_mode | input | 2 | Compare select: bit 0 = 0 equal; 01 less-or-equal; 11 less-than |
| poly_we | input | 1 | Polynomial write strobe |
| poly_wdata | input | WIDTH | Polynomial write value |
| seed_we | input | 1 | Seed write strobe |
| seed_wdata | input | WIDTH | Seed write value |
| ser_in | input | 1 | Serial data input |
| primary_out | output | 1 | State MSB, or ser_in in pass mode |
| aux_out | output | 1 | Compare result, or clk in pass mode |
| irq_out | output | 1 | Registered interrupt |

## Verification
On every cycle the assertions check that the state holds while the block is disabled or passing, and that a seed written while disabled lands in the state. They also check that the primary output tracks the state MSB, that aux_out is quiet while disabled, that an enabled compare hit is followed by an interrupt, and that a rising data input in pass mode does the same. The scenarios are needed for the numeric content: whether the Galois step with the data input folded in gives the right CRC, whether a new polynomial is picked up, that the compare thresholds are exact at the seed value, and that a maximal polynomial shows the epoch exactly once in 255 steps.

// File: rtl/crc_prs_pkg.sv
package crc_prs_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_LE  = 2'b01,
    CMP_EQ2 = 2'b10,
    CMP_LT  = 2'b11
  } cmp_sel_e;

  function automatic logic cmp_eval(input logic [1:0] sel, input logic lt, input logic eq);
    if (!sel[0]) return eq;
    if (sel[1])  return lt;
    return lt | eq;
  endfunction
endpackage

// File: rtl/crc_prs_lfsr.sv
module crc_prs_lfsr #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY_INIT = 8'h1D,
  parameter logic [WIDTH-1:0] SEED_INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             load_ok,
  input  logic             poly_we,
  input  logic [WIDTH-1:0] poly_wdata,
  input  logic             seed_we,
  input  logic [WIDTH-1:0] seed_wdata,
  input  logic             ser_in,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] seed_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] poly_q;
  logic [WIDTH-1:0] state_nxt;
  logic             fb;

  assign fb = state_q[MSB] ^ ser_in;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign state_nxt[i] = fb & poly_q[i];
      end else begin : g_up
        assign state_nxt[i] = state_q[i-1] ^ (fb & poly_q[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      poly_q  <= POLY_INIT;
      seed_q  <= SEED_INIT;
      state_q <= SEED_INIT;
    end else begin
      if (poly_we) poly_q <= poly_wdata;
      if (seed_we) seed_q <= seed_wdata;
      if (seed_we && load_ok) state_q <= seed_wdata;
      else if (step_en)       state_q <= state_nxt;
    end
  end
endmodule

// File: rtl/crc_prs_cmp.sv
module crc_prs_cmp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] seed,
  input  logic [1:0]       sel,
  output logic             hit
);
  import crc_prs_pkg::*;

  logic is_eq;
  logic is_lt;

  assign is_eq = (state == seed);
  assign is_lt = (state < seed);

  always_comb begin
    hit = cmp_eval(sel, is_lt, is_eq);
  end
endmodule

// File: rtl/crc_prs_out.sv
module crc_prs_out (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pass_mode,
  input  logic ser_in,
  input  logic state_msb,
  input  logic cmp_hit,
  output logic primary_out,
  output logic aux_out,
  output logic irq_out
);
  logic din_q;
  logic irq_q;
  logic live_hit;

  assign live_hit = enable & cmp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      din_q <= ser_in;
      irq_q <= pass_mode ? (ser_in & ~din_q) : live_hit;
    end
  end

  assign primary_out = pass_mode ? ser_in : state_msb;
  assign aux_out     = pass_mode ? clk    : live_hit;
  assign irq_out     = irq_q;
endmodule

// File: rtl/crc_prs_core.sv
module crc_prs_core #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY_INIT = 8'h1D,
  parameter logic [WIDTH-1:0] SEED_INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             pass_mode,
  input  logic [1:0]       cmp_mode,
  input  logic             poly_we,
  input  logic [WIDTH-1:0] poly_wdata,
  input  logic             seed_we,
  input  logic [WIDTH-1:0] seed_wdata,
  input  logic             ser_in,
  output logic             primary_out,
  output logic             aux_out,
  output logic             irq_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] seed_q;
  logic             cmp_hit;
  logic             step_en;

  assign step_en = enable & ~pass_mode;

  crc_prs_lfsr #(
    .WIDTH(WIDTH), .POLY_INIT(POLY_INIT), .SEED_INIT(SEED_INIT)
  ) u_lfsr (
    .clk(clk), .rst(rst), .step_en(step_en), .load_ok(~enable),
    .poly_we(poly_we), .poly_wdata(poly_wdata),
    .seed_we(seed_we), .seed_wdata(seed_wdata),
    .ser_in(ser_in), .state_q(state_q), .seed_q(seed_q)
  );

  crc_prs_cmp #(.WIDTH(WIDTH)) u_cmp (
    .state(state_q), .seed(seed_q), .sel(cmp_mode), .hit(cmp_hit)
  );

  crc_prs_out u_out (
    .clk(clk), .rst(rst), .enable(enable), .pass_mode(pass_mode),
    .ser_in(ser_in), .state_msb(state_q[MSB]), .cmp_hit(cmp_hit),
    .primary_out(primary_out), .aux_out(aux_out), .irq_out(irq_out)
  );
endmodule

// File: rtl/crc_prs_core_chk.sv
module crc_prs_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             pass_mode,
  input logic             seed_we,
  input logic [WIDTH-1:0] seed_wdata,
  input logic             ser_in,
  input logic [WIDTH-1:0] state_q,
  input logic             primary_out,
  input logic             aux_out,
  input logic             irq_out
);
  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_we && !enable) |=> (state_q == $past(seed_wdata)));

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_we && (!enable || pass_mode)) |=> $stable(state_q));

  // R6
  prim_msb_chk: assert property (@(posedge clk) disable iff (rst)
    !pass_mode |-> (primary_out == state_q[WIDTH-1]));

  // R9
  aux_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !pass_mode) |-> !aux_out);

  // R10
  cmp_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !pass_mode && aux_out) |=> irq_out);

  // R12
  pass_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_mode && ser_in && !$past(ser_in)) |=> irq_out);
endmodule

bind crc_prs_core crc_prs_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .pass_mode(pass_mode),
  .seed_we(seed_we), .seed_wdata(seed_wdata), .ser_in(ser_in),
  .state_q(state_q), .primary_out(primary_out), .aux_out(aux_out),
  .irq_out(irq_out)
);

// File: tb/crc_prs_core_tb_top.sv
`timescale 1ns/1ps
module crc_prs_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0, pass_mode = 1'b0;
  logic [1:0] cmp_mode = 2'b00;
  logic       poly_we = 1'b0, seed_we = 1'b0, ser_in = 1'b0;
  logic [7:0] poly_wdata = 8'h00, seed_wdata = 8'h00;
  logic       primary_out, aux_out, irq_out;

  always #2 clk = ~clk;

  crc_prs_core dut_i (
    .clk(clk), .rst(rst), .enable(enable), .pass_mode(pass_mode),
    .cmp_mode(cmp_mode), .poly_we(poly_we), .poly_wdata(poly_wdata),
    .seed_we(seed_we), .seed_wdata(seed_wdata), .ser_in(ser_in),
    .primary_out(primary_out), .aux_out(aux_out), .irq_out(irq_out)
  );

  typedef struct {
    logic  prim;
    logic  aux;
    logic  irq;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_state = 8'hFF, m_seed = 8'hFF, m_poly = 8'h1D;
  logic       m_dinq = 1'b0;

  function automatic logic m_cmp(logic [7:0] s, logic [7:0] d, logic [1:0] m);
    if (m[0] == 1'b0) return s == d;
    if (m[1]) return s < d;
    return s <= d;
  endfunction

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit e, input bit p, input logic [1:0] m,
                      input bit pwe, input logic [7:0] pd,
                      input bit swe, input logic [7:0] sd,
                      input bit d, input string tag);
    exp_t it;
    logic       nirq, fb;
    logic [7:0] nstate;
    @(negedge clk);
    enable = e; pass_mode = p; cmp_mode = m;
    poly_we = pwe; poly_wdata = pd; seed_we = swe; seed_wdata = sd; ser_in = d;
    nirq = p ? (d & ~m_dinq) : (e & m_cmp(m_state, m_seed, m));
    nstate = m_state;
    if (swe && !e) nstate = sd;
    else if (e && !p) begin
      fb = m_state[7] ^ d;
      nstate = {m_state[6:0], 1'b0} ^ (fb ? m_poly : 8'h00);
    end
    m_state = nstate;
    if (swe) m_seed = sd;
    if (pwe) m_poly = pd;
    m_dinq = d;
    it.prim = p ? d : m_state[7];
    it.aux  = p ? 1'b1 : (e & m_cmp(m_state, m_seed, m));
    it.irq  = nirq;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.tag, primary_out, it.prim, "primary_out");
      check(it.tag, aux_out, it.aux, "aux_out");
      check(it.tag, irq_out, it.irq, "irq_out");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hits;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", primary_out, 1'b1, "primary_out");
    check("R1", aux_out, 1'b0, "aux_out");
    check("R1", irq_out, 1'b0, "irq_out");
    rst = 1'b0;

    // R3 polynomial write while disabled, R2 seed load while disabled
    step(0, 0, 2'b00, 1, 8'h1D, 0, 8'h00, 0, "R3");
    step(0, 0, 2'b00, 0, 8'h00, 1, 8'h01, 0, "R2");
    step(0, 0, 2'b00, 0, 8'h00, 1, 8'h80, 0, "R2");
    step(0, 0, 2'b00, 0, 8'h00, 1, 8'h01, 0, "R2");

    // R4 R6 R7 R9 R10 full PRS period, epoch exactly once
    hits = 0;
    for (int k = 0; k < 255; k++) begin
      step(1, 0, 2'b00, 0, 8'h00, 0, 8'h00, 0, "R7");
      @(posedge clk); #1;
      if (aux_out) hits++;
    end
    check("R7", hits == 1, 1'b1, "epoch count is one");

    // R5 hold while disabled
    for (int k = 0; k < 4; k++) step(0, 0, 2'b00, 0, 8'h00, 0, 8'h00, k[0], "R5");

    // R2 seed write while enabled leaves state alone
    step(1, 0, 2'b10, 0, 8'h00, 1, 8'h5A, 0, "R2");
    step(1, 0, 2'b10, 0, 8'h00, 0, 8'h00, 0, "R2");

    // R4 CRC with data, R3 polynomial change while running
    for (int k = 0; k < 12; k++) step(1, 0, 2'b00, 0, 8'h00, 0, 8'h00, (k % 3) == 1, "R4");
    step(1, 0, 2'b00, 1, 8'h07, 0, 8'h00, 1, "R3");
    for (int k = 0; k < 12; k++) step(1, 0, 2'b00, 0, 8'h00, 0, 8'h00, k[1], "R4");

    // R8 thresholds at the seed value
    step(0, 0, 2'b01, 0, 8'h00, 1, 8'h40, 0, "R8");
    step(1, 0, 2'b01, 0, 8'h00, 0, 8'h00, 0, "R8");
    step(0, 0, 2'b11, 0, 8'h00, 1, 8'h40, 0, "R8");
    step(1, 0, 2'b11, 0, 8'h00, 0, 8'h00, 0, "R8");
    for (int k = 0; k < 16; k++) step(1, 0, k[0] ? 2'b11 : 2'b01, 0, 8'h00, 0, 8'h00, 0, "R8");
    step(0, 0, 2'b01, 0, 8'h00, 1, 8'hC0, 0, "R8");
    for (int k = 0; k < 8; k++) step(1, 0, 2'b01, 0, 8'h00, 0, 8'h00, 0, "R8");

    // R11 R12 pass mode
    step(1, 1, 2'b00, 0, 8'h00, 0, 8'h00, 0, "R11");
    step(1, 1, 2'b00, 0, 8'h00, 0, 8'h00, 1, "R12");
    step(1, 1, 2'b00, 0, 8'h00, 0, 8'h00, 1, "R12");
    step(1, 1, 2'b00, 0, 8'h00, 0, 8'h00, 0, "R12");
    step(1, 1, 2'b00, 0, 8'h00, 0, 8'h00, 1, "R12");
    @(negedge clk);
    check("R11", aux_out, 1'b0, "aux_out low with clk low");
    step(0, 0, 2'b00, 0, 8'h00, 0, 8'h00, 0, "R5");
    step(1, 0, 2'b00, 0, 8'h00, 0, 8'h00, 0, "R4");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule